// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when the clocks of a small processor core and of its peripherals are allowed to run. It drives three enables, one for the core clock gate, one for the peripheral clock gate and one for the oscillator, and it reports the current mode as a two-bit code. The core requests a mode by pulsing a write strobe with a mode code (00 run, 01 idle, 10 sleep). In idle, only the core clock is stopped. The peripherals keep running, and a timer event, a serial receive event or an external interrupt brings the core back on the next edge. In sleep, both clock domains and the oscillator are stopped. Only an external interrupt or a reset ends sleep.

Leaving sleep turns the oscillator back on and then starts a startup wait. The wait is a down-counter loaded from the `STARTUP_CYCLES` parameter, and it counts edges of the free-running low-speed reference clock that runs all of this block's logic. Neither clock enable rises until the count has run out. The same wait follows a reset. A short count suits a fast-start oscillator that settles in 10 to 15 µs. The default of 12 corresponds to a 1 MHz reference. `STARTUP_CYCLES` must be at least 1.

All inputs other than `rst_n` are synchronous to `clk_ref`. `rst_n` is asserted asynchronously and released through a two-stage synchronizer.

Top module: `lpc_power_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_clk_en` and `peri_clk_en` are 0, `osc_en` is 1 and `mode_now` is 00. After `rst_n` rises, both clock enables become 1 at the (`STARTUP_CYCLES`+2)-th rising edge of `clk_ref` and not before.
- R2: In run mode `core_clk_en`, `peri_clk_en` and `osc_en` are all 1 and `mode_now` is 00.
- R3: In run mode, a `mode_wr` pulse with `mode_code` 01 and no wake source active enters idle at that edge. From then on `core_clk_en` is 0, `peri_clk_en` is 1, `osc_en` is 1 and `mode_now` is 01.
- R4: In run mode, a `mode_wr` pulse with `mode_code` 10 and no wake source active enters sleep at that edge. From then on `core_clk_en`, `peri_clk_en` and `osc_en` are 0 and `mode_now` is 10.
- R5: In idle, any of `tmr_evt`, `rx_evt` or `ext_irq` high at an edge returns the block to run at that edge, with `mode_now` back to 00.
- R6: In sleep, `tmr_evt` and `rx_evt` have no effect. The outputs stay at their sleep values while `ext_irq` is low.
- R7: In sleep, `ext_irq` high at an edge sets `osc_en` to 1 and `mode_now` to 00 at that edge. The clock enables stay 0 until exactly `STARTUP_CYCLES` further edges have passed, and then both become 1.
- R8: A `mode_wr` pulse in run mode is dropped when `ext_irq`, `tmr_evt` or `rx_evt` is high in the same cycle, and the block stays in run.
- R9: A `mode_wr` pulse with `mode_code` 00 or 11 changes nothing. A `mode_wr` pulse outside run mode is also ignored.
- R10: Pulling `rst_n` low from any mode immediately forces the clock enables to 0, `osc_en` to 1 and `mode_now` to 00, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running low-speed reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle strobe: request the mode given by `mode_code` |
| mode_code | input | 2 | Requested mode: 00 run, 01 idle, 10 sleep, 11 reserved |
| ext_irq | input | 1 | External interrupt wake source |
| tmr_evt | input | 1 | Timer event wake source (effective in idle) |
| rx_evt | input | 1 | Serial receive event wake source (effective in idle) |
| core_clk_en | output | 1 | Enable for the core clock gate |
| peri_clk_en | output | 1 | Enable for the peripheral clock gate |
| osc_en | output | 1 | Oscillator enable |
| mode_now | output | 2 | Current mode code, 00 in run and during the startup wait |

## Verification
Mode entries and idle wakes appear on the outputs just after the edge that samples the request. An asynchronous reset appears without any edge. Enables after a sleep wake appear `STARTUP_CYCLES` edges after the interrupt edge, and after reset release they appear `STARTUP_CYCLES`+2 edges later. The bench keeps its own cycle model, stepped at each rising edge from the inputs it drove at the preceding falling edge. It compares every output at the following falling edge, so each of these latencies is checked at the exact edge where it is due. For the reset case, the bench samples one nanosecond after `rst_n` falls.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    ST_WARM  = 2'b00,
    ST_RUN   = 2'b01,
    ST_IDLE  = 2'b10,
    ST_SLEEP = 2'b11
  } lpc_state_e;

  localparam logic [1:0] MODE_RUN   = 2'b00;
  localparam logic [1:0] MODE_IDLE  = 2'b01;
  localparam logic [1:0] MODE_SLEEP = 2'b10;

endpackage

// File: rtl/lpc_rst_sync.sv
module lpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/lpc_startup_timer.sv
module lpc_startup_timer #(
  parameter int CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_en = load | (run & ~done);
    cnt_d  = load ? LOAD_VAL : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);                                  // R7
  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == LOAD_VAL));                              // R7

endmodule

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_code,
  input  logic       ext_irq,
  input  logic       tmr_evt,
  input  logic       rx_evt,
  input  logic       tmr_done,
  output lpc_state_e state,
  output logic       tmr_load,
  output logic       tmr_run
);

  lpc_state_e st_d;
  logic       st_en;
  logic       wake_any;

  assign wake_any = ext_irq | tmr_evt | rx_evt;

  always_comb begin
    st_d     = state;
    tmr_load = 1'b0;
    case (state)
      ST_WARM:  if (tmr_done) st_d = ST_RUN;
      ST_RUN: begin
        if (mode_wr && !wake_any) begin
          if (mode_code == MODE_IDLE)       st_d = ST_IDLE;
          else if (mode_code == MODE_SLEEP) st_d = ST_SLEEP;
        end
      end
      ST_IDLE:  if (wake_any) st_d = ST_RUN;
      ST_SLEEP: begin
        if (ext_irq) begin
          st_d     = ST_WARM;
          tmr_load = 1'b1;
        end
      end
      default:  st_d = ST_WARM;
    endcase
  end

  assign st_en   = (st_d != state);
  assign tmr_run = (state == ST_WARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= ST_WARM;
    else if (st_en) state <= st_d;
  end

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && mode_wr && mode_code == MODE_IDLE && !wake_any)
      |=> state == ST_IDLE);                                    // R3
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && mode_wr && mode_code == MODE_SLEEP && !wake_any)
      |=> state == ST_SLEEP);                                   // R4
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wake_any) |=> state == ST_RUN);        // R5
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !ext_irq) |=> state == ST_SLEEP);     // R6
  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && ext_irq) |=> state == ST_WARM);       // R7
  AST_WAKE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && wake_any) |=> state == ST_RUN);         // R8

endmodule

// File: rtl/lpc_clk_enables.sv
module lpc_clk_enables
  import lpc_pkg::*;
(
  input  lpc_state_e state,
  output logic       core_clk_en,
  output logic       peri_clk_en,
  output logic       osc_en,
  output logic [1:0] mode_now
);

  always_comb begin
    core_clk_en = 1'b0;
    peri_clk_en = 1'b0;
    osc_en      = 1'b1;
    mode_now    = MODE_RUN;
    case (state)
      ST_RUN: begin
        core_clk_en = 1'b1;
        peri_clk_en = 1'b1;
      end
      ST_IDLE: begin
        peri_clk_en = 1'b1;
        mode_now    = MODE_IDLE;
      end
      ST_SLEEP: begin
        osc_en   = 1'b0;
        mode_now = MODE_SLEEP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpc_power_ctrl.sv
module lpc_power_ctrl
  import lpc_pkg::*;
#(
  parameter int STARTUP_CYCLES = 12,
  parameter int RST_STAGES     = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_code,
  input  logic       ext_irq,
  input  logic       tmr_evt,
  input  logic       rx_evt,
  output logic       core_clk_en,
  output logic       peri_clk_en,
  output logic       osc_en,
  output logic [1:0] mode_now
);

  logic       rst_n_s;
  lpc_state_e state;
  logic       tmr_load;
  logic       tmr_run;
  logic       tmr_done;

  lpc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lpc_startup_timer #(.CYCLES(STARTUP_CYCLES)) u_timer (
    .clk   (clk_ref),
    .rst_n (rst_n_s),
    .load  (tmr_load),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  lpc_mode_fsm u_fsm (
    .clk       (clk_ref),
    .rst_n     (rst_n_s),
    .mode_wr   (mode_wr),
    .mode_code (mode_code),
    .ext_irq   (ext_irq),
    .tmr_evt   (tmr_evt),
    .rx_evt    (rx_evt),
    .tmr_done  (tmr_done),
    .state     (state),
    .tmr_load  (tmr_load),
    .tmr_run   (tmr_run)
  );

  lpc_clk_enables u_enables (
    .state       (state),
    .core_clk_en (core_clk_en),
    .peri_clk_en (peri_clk_en),
    .osc_en      (osc_en),
    .mode_now    (mode_now)
  );

  AST_RELEASE_AFTER_WAIT: assert property (@(posedge clk_ref) disable iff (!rst_n_s)
    $rose(peri_clk_en) |-> tmr_done);                           // R7
  AST_OSC_STAYS_OFF: assert property (@(posedge clk_ref) disable iff (!rst_n_s)
    (!osc_en && !ext_irq) |=> !osc_en);                         // R6
  AST_CORE_NEEDS_OSC: assert property (@(posedge clk_ref) disable iff (!rst_n_s)
    $rose(osc_en) |-> !core_clk_en);                            // R7

endmodule

// File: tb/tb_lpc_power_ctrl.sv
module tb_lpc_power_ctrl;

  localparam int SC = 12;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [1:0] mode_code;
  logic       ext_irq;
  logic       tmr_evt;
  logic       rx_evt;
  logic       core_clk_en;
  logic       peri_clk_en;
  logic       osc_en;
  logic [1:0] mode_now;

  int checks = 0;
  int errors = 0;

  // bench model: 0 startup wait, 1 run, 2 idle, 3 sleep
  int m_st;
  int m_rem;
  int m_sync;

  always #10 clk_ref = ~clk_ref;

  lpc_power_ctrl #(.STARTUP_CYCLES(SC)) dut (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_code   (mode_code),
    .ext_irq     (ext_irq),
    .tmr_evt     (tmr_evt),
    .rx_evt      (rx_evt),
    .core_clk_en (core_clk_en),
    .peri_clk_en (peri_clk_en),
    .osc_en      (osc_en),
    .mode_now    (mode_now)
  );

  function automatic logic [4:0] exp_out(int st);
    logic c, p, o;
    logic [1:0] m;
    c = (st == 1);
    p = (st == 1) || (st == 2);
    o = (st != 3);
    m = (st == 2) ? 2'b01 : (st == 3) ? 2'b10 : 2'b00;
    return {c, p, o, m};
  endfunction

  function automatic string st_tag(int st);
    case (st)
      1:       return "R2";
      2:       return "R3";
      3:       return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic model_reset();
    m_st = 0; m_rem = SC; m_sync = 0;
  endtask

  task automatic model_step();
    logic wake;
    wake = ext_irq | tmr_evt | rx_evt;
    if (!rst_n) model_reset();
    else if (m_sync < 2) m_sync++;
    else begin
      case (m_st)
        0: if (m_rem == 1) m_st = 1; else m_rem--;
        1: if (mode_wr && !wake) begin
             if (mode_code == 2'b01) m_st = 2;
             else if (mode_code == 2'b10) m_st = 3;
           end
        2: if (wake) m_st = 1;
        default: if (ext_irq) begin m_st = 0; m_rem = SC; end
      endcase
    end
  endtask

  task automatic check(string tag);
    logic [4:0] got, exp;
    got = {core_clk_en, peri_clk_en, osc_en, mode_now};
    exp = exp_out(m_st);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s core/peri/osc/mode got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(logic wr, logic [1:0] code, logic irq, logic tm, logic rx, string tag);
    mode_wr = wr; mode_code = code; ext_irq = irq; tmr_evt = tm; rx_evt = rx;
    @(posedge clk_ref);
    model_step();
    @(negedge clk_ref);
    mode_wr = 1'b0; ext_irq = 1'b0; tmr_evt = 1'b0; rx_evt = 1'b0;
    check(tag);
  endtask

  task automatic release_reset();
    @(negedge clk_ref);
    rst_n = 1'b1;
    for (int i = 0; i < SC + 2; i++) cyc(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, "R1");
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode_wr = 1'b0; mode_code = 2'b00;
    ext_irq = 1'b0; tmr_evt = 1'b0; rx_evt = 1'b0;
    model_reset();
    #35;
    check("R1");
    release_reset();

    cyc(0, 2'b00, 0, 0, 0, "R2");
    cyc(1, 2'b11, 0, 0, 0, "R9");
    cyc(1, 2'b00, 0, 0, 0, "R9");
    cyc(1, 2'b01, 0, 0, 0, "R3");
    cyc(1, 2'b10, 0, 0, 0, "R9");
    cyc(0, 2'b00, 0, 1, 0, "R5");
    cyc(1, 2'b01, 0, 0, 0, "R3");
    cyc(0, 2'b00, 0, 0, 1, "R5");
    cyc(1, 2'b01, 0, 0, 0, "R3");
    cyc(0, 2'b00, 1, 0, 0, "R5");
    cyc(1, 2'b10, 0, 1, 0, "R8");
    cyc(1, 2'b01, 1, 0, 0, "R8");
    cyc(1, 2'b10, 0, 0, 1, "R8");
    cyc(1, 2'b10, 0, 0, 0, "R4");
    cyc(0, 2'b00, 0, 1, 0, "R6");
    cyc(0, 2'b00, 0, 0, 1, "R6");
    cyc(1, 2'b01, 0, 0, 0, "R9");
    cyc(0, 2'b00, 1, 0, 0, "R7");
    for (int i = 0; i < SC; i++) cyc(0, 2'b00, 0, 0, 0, "R7");

    cyc(1, 2'b10, 0, 0, 0, "R4");
    #5;
    rst_n = 1'b0;
    model_reset();
    #1;
    check("R10");
    release_reset();
    cyc(1, 2'b01, 0, 0, 0, "R3");
    #5;
    rst_n = 1'b0;
    model_reset();
    #1;
    check("R10");
    release_reset();

    for (int i = 0; i < 4000; i++) begin
      logic       wr, irq, tm, rx;
      logic [1:0] code;
      wr   = ($urandom % 4) == 0;
      code = 2'($urandom % 4);
      irq  = ($urandom % 16) == 0;
      tm   = ($urandom % 12) == 0;
      rx   = ($urandom % 12) == 0;
      cyc(wr, code, irq, tm, rx, st_tag(m_st));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule